// File: doc/BRIEF.md
# Indirect Register Access Window

This block exposes a large memory-mapped register space through a tiny 32-byte window that holds two active registers: a pointer register and a port register. Software first loads the pointer with the byte address of the register it wants, then reads or writes the port register. Each port access is passed on as a single-cycle access to the main register file, at the address held in the pointer.

The main register file has one master port. This block shares that port between its own forwarded accesses and a direct access path. When both want the port in the same cycle, the direct path wins. A forwarded window access is then held off through a ready signal until the port is free. All window reads return their data one cycle after they are accepted, from a register.

Top module: `idxw_top`

## Requirements
- R1: After reset the pointer register holds zero, `win_rvalid` is low, `win_rdata` is zero and `m_req` is low.
- R2: The pointer register is at window byte offset IDX_OFFSET (default 8). A write to it stores the written value ANDed with TGT_BYTES-1 (default 0xFFF), with bits 1:0 forced to zero. A read of it returns the stored pointer, zero-extended to 32 bits.
- R3: A write to the port register, at window offset IDX_OFFSET+4 (default 12), drives `m_req`=1, `m_we`=1, `m_addr` equal to the pointer and `m_wdata` equal to the written value, in the same cycle the write is accepted.
- R4: A read of the port register returns the value of the main register space at the pointer. That value is sampled from `m_rdata` in the acceptance cycle and presented on `win_rdata` one cycle later.
- R5: A read of any other window offset returns zero. A write to any other offset changes neither the pointer nor the main space, and raises no `m_req`.
- R6: When `dir_req` is high, the master port carries the direct access and `dir_rdata` follows `m_rdata`. A port-register access in the same cycle sees `win_ready`=0 and goes through once `dir_req` falls. Pointer accesses are never stalled.
- R7: `win_rvalid` is high for exactly one cycle after each accepted window read and is never high after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_req | input | 1 | Window access request |
| win_we | input | 1 | Window access is a write |
| win_addr | input | 5 | Window byte offset |
| win_wdata | input | 32 | Window write data |
| win_ready | output | 1 | Window access accepted this cycle |
| win_rvalid | output | 1 | Window read data valid |
| win_rdata | output | 32 | Registered window read data |
| dir_req | input | 1 | Direct access request (priority) |
| dir_we | input | 1 | Direct access is a write |
| dir_addr | input | 12 | Direct byte address |
| dir_wdata | input | 32 | Direct write data |
| dir_rdata | output | 32 | Direct read data |
| m_req | output | 1 | Main register file request |
| m_we | output | 1 | Main register file write |
| m_addr | output | 12 | Main register file byte address |
| m_wdata | output | 32 | Main register file write data |
| m_rdata | input | 32 | Main register file read data, same cycle |

## Verification
Pointer writes use an all-ones value, an unaligned value with high garbage bits, and zero. These show whether the masking clips the upper bits and clears the alignment bits separately. Port writes and reads run at the lowest, highest and a middle word of the target space, each with a distinct value, so an address taken from the wrong source or an unregistered read shows up as a data mismatch. Accesses to unused offsets are followed by a pointer read-back and a port read, which expose any side effect. A direct write followed by a colliding window access checks both the priority and that the stalled access completes afterwards.

// File: rtl/idxw_pkg.sv
// Package: shared types for the indirect register window.
// Assumes: window offsets are decoded to exactly one of three selections.
package idxw_pkg;
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_INDEX = 2'd1,
        SEL_DATA  = 2'd2
    } win_sel_t;
endpackage

// File: rtl/idxw_decode.sv
// Module: idxw_decode
// Decodes a window byte offset into pointer, port or unused.
// Assumes: IDX_OFFSET+4 fits in the window; only exact offsets hit.
module idxw_decode
    import idxw_pkg::*;
#(
    parameter int WIN_BYTES  = 32,
    parameter int IDX_OFFSET = 8,
    localparam int WAW       = $clog2(WIN_BYTES)
) (
    input  logic [WAW-1:0] addr,
    output win_sel_t       sel
);
    localparam logic [WAW-1:0] PTR_OFF  = WAW'(IDX_OFFSET);
    localparam logic [WAW-1:0] PORT_OFF = WAW'(IDX_OFFSET + 4);

    // Compare the offset against the two active register locations.
    always_comb begin
        if (addr == PTR_OFF)       sel = SEL_INDEX;
        else if (addr == PORT_OFF) sel = SEL_DATA;
        else                       sel = SEL_NONE;
    end
endmodule

// File: rtl/idxw_index_reg.sv
// Module: idxw_index_reg
// Holds the pointer into the target space, masked and word aligned.
// Assumes: TGT_BYTES is a power of two of at least 4.
module idxw_index_reg #(
    parameter int DW        = 32,
    parameter int TGT_BYTES = 4096,
    localparam int TAW      = $clog2(TGT_BYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [DW-1:0]  wdata,
    output logic [TAW-1:0] idx
);
    // Load the pointer with the masked, aligned write value.
    always_ff @(posedge clk) begin
        if (!rst_n)  idx <= '0;
        else if (we) idx <= {wdata[TAW-1:2], 2'b00};
    end

    // R2: the stored pointer never carries alignment bits.
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> idx[1:0] == 2'b00);
    // R5: without a pointer write the pointer holds its value.
    a_r5_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(idx));
endmodule

// File: rtl/idxw_arbiter.sv
// Module: idxw_arbiter
// Shares the main register file port; the direct path has priority.
// Assumes: the main file answers in the cycle of the request.
module idxw_arbiter #(
    parameter int DW  = 32,
    parameter int TAW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dir_req,
    input  logic           dir_we,
    input  logic [TAW-1:0] dir_addr,
    input  logic [DW-1:0]  dir_wdata,
    input  logic           fwd_req,
    input  logic           fwd_we,
    input  logic [TAW-1:0] fwd_addr,
    input  logic [DW-1:0]  fwd_wdata,
    output logic           fwd_grant,
    output logic           m_req,
    output logic           m_we,
    output logic [TAW-1:0] m_addr,
    output logic [DW-1:0]  m_wdata
);
    // Select the direct access whenever it is present.
    always_comb begin
        fwd_grant = !dir_req;
        if (dir_req) begin
            m_req   = 1'b1;
            m_we    = dir_we;
            m_addr  = dir_addr;
            m_wdata = dir_wdata;
        end else begin
            m_req   = fwd_req;
            m_we    = fwd_req && fwd_we;
            m_addr  = fwd_addr;
            m_wdata = fwd_wdata;
        end
    end

    // R6: a direct request always owns the master port.
    a_r6_dir_prio: assert property (@(posedge clk) disable iff (!rst_n)
        dir_req |-> (m_req && m_addr == dir_addr && m_we == dir_we));
endmodule

// File: rtl/idxw_top.sv
// Module: idxw_top
// 32-byte window with a pointer and a port register giving indirect
// access to a 4 KiB register space, plus a priority direct path.
// Assumes: main file read data is valid in the request cycle.
module idxw_top #(
    parameter int DW         = 32,
    parameter int WIN_BYTES  = 32,
    parameter int IDX_OFFSET = 8,
    parameter int TGT_BYTES  = 4096,
    localparam int WAW       = $clog2(WIN_BYTES),
    localparam int TAW       = $clog2(TGT_BYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           win_req,
    input  logic           win_we,
    input  logic [WAW-1:0] win_addr,
    input  logic [DW-1:0]  win_wdata,
    output logic           win_ready,
    output logic           win_rvalid,
    output logic [DW-1:0]  win_rdata,
    input  logic           dir_req,
    input  logic           dir_we,
    input  logic [TAW-1:0] dir_addr,
    input  logic [DW-1:0]  dir_wdata,
    output logic [DW-1:0]  dir_rdata,
    output logic           m_req,
    output logic           m_we,
    output logic [TAW-1:0] m_addr,
    output logic [DW-1:0]  m_wdata,
    input  logic [DW-1:0]  m_rdata
);
    import idxw_pkg::*;

    win_sel_t       sel;
    logic [TAW-1:0] idx;
    logic           grant;
    logic           accept;
    logic           fwd_req;

    idxw_decode #(.WIN_BYTES(WIN_BYTES), .IDX_OFFSET(IDX_OFFSET)) u_dec (
        .addr (win_addr),
        .sel  (sel)
    );

    idxw_index_reg #(.DW(DW), .TGT_BYTES(TGT_BYTES)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept && win_we && sel == SEL_INDEX),
        .wdata (win_wdata),
        .idx   (idx)
    );

    idxw_arbiter #(.DW(DW), .TAW(TAW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_req   (dir_req),
        .dir_we    (dir_we),
        .dir_addr  (dir_addr),
        .dir_wdata (dir_wdata),
        .fwd_req   (fwd_req),
        .fwd_we    (win_we),
        .fwd_addr  (idx),
        .fwd_wdata (win_wdata),
        .fwd_grant (grant),
        .m_req     (m_req),
        .m_we      (m_we),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata)
    );

    // Only port accesses need the master port; others always proceed.
    always_comb begin
        win_ready = (sel != SEL_DATA) || grant;
        accept    = win_req && win_ready;
        fwd_req   = win_req && sel == SEL_DATA && grant;
        dir_rdata = m_rdata;
    end

    // Capture window read data and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_rvalid <= 1'b0;
            win_rdata  <= '0;
        end else begin
            win_rvalid <= accept && !win_we;
            if (accept && !win_we) begin
                case (sel)
                    SEL_INDEX: win_rdata <= DW'(idx);
                    SEL_DATA:  win_rdata <= m_rdata;
                    default:   win_rdata <= '0;
                endcase
            end
        end
    end

    // R3: an accepted port write reaches the main file at the pointer.
    a_r3_fwd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_we && sel == SEL_DATA)
            |-> (m_req && m_we && m_addr == idx && m_wdata == win_wdata));
    // R5: unused offsets never touch the main file.
    a_r5_no_mreq: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && sel == SEL_NONE && !dir_req) |-> !m_req);
    // R6: a colliding port access is held off.
    a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_req && win_req && sel == SEL_DATA) |-> !win_ready);
    // R7: read valid follows exactly one accepted read.
    a_r7_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        win_rvalid |-> $past(win_req && win_ready && !win_we));
endmodule

// File: tb/idxw_top_tb.sv
module idxw_top_tb;
    localparam int PTR  = 8;
    localparam int PORT = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_req = 1'b0, win_we = 1'b0;
    logic [4:0]  win_addr = '0;
    logic [31:0] win_wdata = '0;
    logic        win_ready, win_rvalid;
    logic [31:0] win_rdata;
    logic        dir_req = 1'b0, dir_we = 1'b0;
    logic [11:0] dir_addr = '0;
    logic [31:0] dir_wdata = '0;
    logic [31:0] dir_rdata;
    logic        m_req, m_we;
    logic [11:0] m_addr;
    logic [31:0] m_wdata, m_rdata;

    int tests = 0, fails = 0;
    logic [31:0] mem [1024];
    logic [31:0] shadow [1024];
    logic [11:0] exp_idx = '0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    idxw_top u_dut (.*);

    // Main register file model: same-cycle read, write at the edge.
    assign m_rdata = mem[m_addr[11:2]];
    always @(posedge clk) if (m_req && m_we) mem[m_addr[11:2]] <= m_wdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected item per read result.
    always @(negedge clk) begin
        if (rst_n && win_rvalid) begin
            if (exp_q.size() == 0) check("R7 unexpected rvalid", 32'd1, 32'd0);
            else check(tag_q.pop_front(), win_rdata, exp_q.pop_front());
        end
    end

    // Driver: one window access, waiting for ready; reads push expectations.
    task automatic win_op(input logic we, input int addr, input logic [31:0] d,
                          input string req);
        @(negedge clk);
        win_req = 1'b1; win_we = we; win_addr = 5'(addr); win_wdata = d;
        #1;
        while (!win_ready) begin @(negedge clk); #1; end
        if (we && addr == PORT) begin
            check({req, " m_req/m_we"}, {30'd0, m_req, m_we}, 32'd3);
            check({req, " m_addr"}, {20'd0, m_addr}, {20'd0, exp_idx});
            check({req, " m_wdata"}, m_wdata, d);
            shadow[exp_idx[11:2]] = d;
        end
        if (addr != PTR && addr != PORT) check("R5 no m_req", {31'd0, m_req}, 32'd0);
        if (!we) begin
            if (addr == PTR)       exp_q.push_back({20'd0, exp_idx});
            else if (addr == PORT) exp_q.push_back(shadow[exp_idx[11:2]]);
            else                   exp_q.push_back(32'd0);
            tag_q.push_back(req);
        end
        if (we && addr == PTR) exp_idx = {d[11:2], 2'b00};
        @(posedge clk); #1;
        win_req = 1'b0;
    endtask

    initial begin
        #100000;
        fails++; tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin mem[i] = '0; shadow[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rvalid", {31'd0, win_rvalid}, 32'd0);
        check("R1 rdata", win_rdata, 32'd0);
        check("R1 m_req", {31'd0, m_req}, 32'd0);
        rst_n = 1'b1;
        win_op(1'b0, PTR, 0, "R1 pointer zero");
        // R2 masking patterns
        win_op(1'b1, PTR, 32'hFFFF_FFFF, "R2");
        win_op(1'b0, PTR, 0, "R2 all-ones masked");
        win_op(1'b1, PTR, 32'hABCD_1237, "R2");
        win_op(1'b0, PTR, 0, "R2 unaligned masked");
        // R3/R4 at top, middle, bottom words
        win_op(1'b1, PTR, 32'hFFC, "R2");
        win_op(1'b1, PORT, 32'hDEAD_BEEF, "R3 top");
        win_op(1'b1, PTR, 32'h234, "R2");
        win_op(1'b1, PORT, 32'h1234_5678, "R3 mid");
        win_op(1'b1, PTR, 32'h0, "R2");
        win_op(1'b1, PORT, 32'hA5A5_0F0F, "R3 bottom");
        win_op(1'b0, PORT, 0, "R4 read bottom");
        win_op(1'b1, PTR, 32'hFFC, "R2");
        win_op(1'b0, PORT, 0, "R4 read top");
        win_op(1'b1, PTR, 32'h234, "R2");
        win_op(1'b0, PORT, 0, "R4 read mid");
        // R5 unused offsets
        win_op(1'b1, 0, 32'h0000_0100, "R5 write off0");
        win_op(1'b1, 16, 32'hFFFF_FFFF, "R5 write off16");
        win_op(1'b0, 0, 0, "R5 read off0");
        win_op(1'b0, 28, 0, "R5 read off28");
        win_op(1'b0, PTR, 0, "R5 pointer unchanged");
        win_op(1'b0, PORT, 0, "R5 main unchanged");
        // R6 direct write, then collision
        @(negedge clk);
        dir_req = 1'b1; dir_we = 1'b1; dir_addr = 12'h234; dir_wdata = 32'hCAFE_0001;
        win_req = 1'b1; win_we = 1'b0; win_addr = 5'(PORT);
        #1;
        check("R6 stall", {31'd0, win_ready}, 32'd0);
        check("R6 m_addr direct", {20'd0, m_addr}, 32'h234);
        win_req = 1'b0;
        shadow[12'h234 >> 2] = 32'hCAFE_0001;
        @(negedge clk);
        dir_we = 1'b0; dir_addr = 12'hFFC;
        #1;
        check("R6 dir_rdata", dir_rdata, 32'hDEAD_BEEF);
        @(negedge clk);
        dir_req = 1'b1; dir_addr = 12'h000;
        fork
            win_op(1'b0, PORT, 0, "R6 stalled read completes");
            begin @(negedge clk); @(negedge clk); dir_req = 1'b0; end
        join
        // R7: writes raise no rvalid (monitor flags any extra)
        win_op(1'b1, PTR, 32'h8, "R7");
        repeat (4) @(negedge clk);
        check("R7 queue drained", exp_q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule